// File: doc/BRIEF.md
# Prescaled Interval Timer

A single 16-bit timer channel with an 8-bit prescaler. It counts down toward zero or up toward an interval value, either once (the enable bit drops at the time-out) or periodically (the counter reloads and keeps running). Each time-out and each match between the count and a programmed match value raises a raw event bit. A mask selects which raw bits show in the masked status, and write-one-to-clear strobes remove them.

Software drives the channel through a single-cycle register write strobe. There are eight word addresses: control, interval load, match, prescale, prescale-match, value, mask and clear. The current count, the live prescaler, the enable state and both status vectors are visible as plain outputs. Control bits choose when new interval and match values take effect: at once, or only at the next time-out.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the count is 0xFFFF, the interval load and match registers are 0xFFFF, the prescaler and the prescale-match register are 0, the timer is stopped, and both status vectors are 0.
- R2: A write at address 0 is a control write with these fields: bit 0 enable, bit 1 stall, bit 2 count up, bits 4:3 mode (1 one-shot, 2 periodic), bit 5 deferred load, bit 6 deferred match, bit 7 match event enable. When a control write sets enable on a stopped timer, the prescaler loads the prescale value (address 3) in down mode, or 0 in up mode.
- R3: In down mode the prescaler counts down by one each cycle. The counter steps only in the cycle in which the prescaler is at 0, so one count lasts prescale+1 cycles. In that same cycle the prescaler reloads.
- R4: In down mode a time-out occurs when the counter is at 0 and its step is due. The counter reloads from the interval load register (address 1), and raw bit 0 sets on the following edge. With interval L and prescale P, this happens (L+1)(P+1) edges after the enabling write.
- R5: In periodic mode (2) the timer stays enabled after a time-out and keeps counting from the reload value.
- R6: In one-shot mode (1) the enable bit clears at the time-out. The count then holds the reloaded value.
- R7: In up mode the prescaler counts from 0 to the prescale value. The counter counts up to the interval load value, and the step after that returns it to 0 with a time-out.
- R8: With deferred load (control bit 5) clear, an interval write places the value in the counter at the write edge. With bit 5 set, the counter is not touched and the new value is used at the next time-out reload.
- R9: A write at address 5 loads data bits 15:0 into the counter at the write edge. Data bits 23:16 are ignored, and the prescaler keeps its value.
- R10: With control bit 7 set, raw bit 1 sets one edge after a counting cycle in which the count equals the active match value and the prescaler equals the active prescale-match value. With bit 7 clear, raw bit 1 never sets.
- R11: With deferred match (control bit 6) clear, writes at addresses 2 and 4 take effect at once. With bit 6 set, they take effect at the next time-out, or when a control write enables a stopped timer.
- R12: The masked status is the raw status ANDed with the mask (address 6, bit 0 time-out, bit 1 match). A write at address 7 clears each raw bit whose data bit is 1 and leaves the rest. An event in the same cycle wins over the clear.
- R13: While stall is set, the counter and the prescaler hold their values.
- R14: In modes 0 and 3 an enabled timer does not count and raises no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle register write strobe |
| wrAddr | input | 3 | Register word address |
| wrData | input | 24 | Write data |
| count | output | 16 | Current counter value |
| prescale | output | 8 | Current free-running prescaler value |
| running | output | 1 | Timer enable state |
| rawIrq | output | 2 | Raw status: bit 0 time-out, bit 1 match |
| maskedIrq | output | 2 | Raw status ANDed with the mask |

## Verification
The prescaler and the counter both drive ports directly. A wrong prescaler phase or a missed counter step therefore shows at the first step that goes wrong, at most prescale+1 cycles after its cause. A wrong reload source or the wrong update-timing choice for interval or match values only shows at the next time-out. The tests therefore check the cycles just before and just after that time-out, and a write made while the timer runs has to be followed through a whole period. A clear that loses to a simultaneous event, or a mask leak, shows in the status outputs one edge after the write.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_LOAD    = 3'd1,
    REG_MATCH   = 3'd2,
    REG_PSC     = 3'd3,
    REG_PSMATCH = 3'd4,
    REG_VALUE   = 3'd5,
    REG_MASK    = 3'd6,
    REG_CLEAR   = 3'd7
  } regAddr_e;

  typedef enum logic [1:0] {
    MODE_RSVD     = 2'd0,
    MODE_ONESHOT  = 2'd1,
    MODE_PERIODIC = 2'd2,
    MODE_CAPTURE  = 2'd3
  } mode_e;

  localparam int EVT_TIMEOUT = 0;
  localparam int EVT_MATCH   = 1;
  localparam int NUM_EVT     = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic step;       // one counting cycle
    logic start;      // stopped -> enabled
    logic startUp;    // direction being written with start
    logic countUp;    // current direction
    logic forceLoad;  // load counter from forceVal
    logic matchIrqEn; // match events allowed
  } dpStrobe_t;
endpackage

// File: rtl/tmr_datapath.sv
`timescale 1ns/1ps
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        st,
  input  logic [CNT_W-1:0] forceVal,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [PS_W-1:0]  pscale,
  input  logic [CNT_W-1:0] matchVal,
  input  logic [PS_W-1:0]  psMatchVal,
  output logic             timeoutEvt,
  output logic             matchEvt,
  output logic [CNT_W-1:0] cnt,
  output logic [PS_W-1:0]  ps
);
  logic psTerm;
  logic atLimit;
  logic [PS_W-1:0] psReload;
  logic [CNT_W-1:0] cntReload;

  assign psTerm    = st.countUp ? (ps >= pscale) : (ps == '0);
  assign atLimit   = st.countUp ? (cnt == loadVal) : (cnt == '0);
  assign psReload  = st.countUp ? '0 : pscale;
  assign cntReload = st.countUp ? '0 : loadVal;

  assign timeoutEvt = st.step && psTerm && atLimit;
  assign matchEvt   = st.step && st.matchIrqEn && (cnt == matchVal) && (ps == psMatchVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ps <= '0;
    end else if (st.start) begin
      ps <= st.startUp ? '0 : pscale;
    end else if (st.step) begin
      if (psTerm)          ps <= psReload;
      else if (st.countUp) ps <= ps + 1'b1;
      else                 ps <= ps - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '1;
    end else if (st.forceLoad) begin
      cnt <= forceVal;
    end else if (st.step && psTerm) begin
      if (atLimit)         cnt <= cntReload;
      else if (st.countUp) cnt <= cnt + 1'b1;
      else                 cnt <= cnt - 1'b1;
    end
  end

  // R3
  cnt_waits_prescaler_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.step && !psTerm && !st.forceLoad) |=> $stable(cnt));

  // R13
  ps_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.step && !st.start) |=> $stable(ps));

  // R4
  down_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutEvt && !st.countUp && !st.forceLoad) |=> (cnt == $past(loadVal)));

  // R7
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutEvt && st.countUp && !st.forceLoad) |=> (cnt == '0));
endmodule

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8,
  localparam int DATA_W = CNT_W + PS_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               timeoutEvt,
  input  logic               matchEvt,
  output dpStrobe_t          st,
  output logic [CNT_W-1:0]   forceVal,
  output logic [CNT_W-1:0]   loadVal,
  output logic [PS_W-1:0]    pscale,
  output logic [CNT_W-1:0]   matchVal,
  output logic [PS_W-1:0]    psMatchVal,
  output logic [NUM_EVT-1:0] rawIrq,
  output logic [NUM_EVT-1:0] maskedIrq,
  output logic               running
);
  logic enReg, stallReg, upReg, ldDefer, mDefer, mIe;
  mode_e modeReg;
  logic [CNT_W-1:0] loadReg, matchPend, matchAct;
  logic [PS_W-1:0]  pscReg, psmPend, psmAct;
  logic [NUM_EVT-1:0] maskReg, rawReg, evtVec, clrVec;
  logic ctrlWr, loadWr, matchWr, pscWr, psmWr, valueWr, maskWr, clearWr;
  logic startNow, unusedHi;

  assign unusedHi = ^wrData[DATA_W-1:CNT_W];

  assign ctrlWr  = wrEn && (wrAddr == REG_CTRL);
  assign loadWr  = wrEn && (wrAddr == REG_LOAD);
  assign matchWr = wrEn && (wrAddr == REG_MATCH);
  assign pscWr   = wrEn && (wrAddr == REG_PSC);
  assign psmWr   = wrEn && (wrAddr == REG_PSMATCH);
  assign valueWr = wrEn && (wrAddr == REG_VALUE);
  assign maskWr  = wrEn && (wrAddr == REG_MASK);
  assign clearWr = wrEn && (wrAddr == REG_CLEAR);

  assign startNow = ctrlWr && wrData[0] && !enReg;

  always_comb begin
    st.step       = enReg && !stallReg &&
                    (modeReg == MODE_ONESHOT || modeReg == MODE_PERIODIC);
    st.start      = startNow;
    st.startUp    = wrData[2];
    st.countUp    = upReg;
    st.forceLoad  = valueWr || (loadWr && !ldDefer);
    st.matchIrqEn = mIe;
  end

  assign forceVal   = wrData[CNT_W-1:0];
  assign loadVal    = loadReg;
  assign pscale     = pscReg;
  assign matchVal   = matchAct;
  assign psMatchVal = psmAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg <= 1'b0; stallReg <= 1'b0; upReg <= 1'b0;
      ldDefer <= 1'b0; mDefer <= 1'b0; mIe <= 1'b0;
      modeReg <= MODE_RSVD;
    end else if (ctrlWr) begin
      enReg    <= wrData[0];
      stallReg <= wrData[1];
      upReg    <= wrData[2];
      modeReg  <= mode_e'(wrData[4:3]);
      ldDefer  <= wrData[5];
      mDefer   <= wrData[6];
      mIe      <= wrData[7];
    end else if (timeoutEvt && modeReg == MODE_ONESHOT) begin
      enReg <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadReg <= '1;
      pscReg  <= '0;
      maskReg <= '0;
    end else begin
      if (loadWr) loadReg <= wrData[CNT_W-1:0];
      if (pscWr)  pscReg  <= wrData[PS_W-1:0];
      if (maskWr) maskReg <= wrData[NUM_EVT-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchPend <= '1; matchAct <= '1;
      psmPend   <= '0; psmAct   <= '0;
    end else begin
      if (timeoutEvt || startNow) begin
        matchAct <= matchPend;
        psmAct   <= psmPend;
      end
      if (matchWr) begin
        matchPend <= wrData[CNT_W-1:0];
        if (!mDefer) matchAct <= wrData[CNT_W-1:0];
      end
      if (psmWr) begin
        psmPend <= wrData[PS_W-1:0];
        if (!mDefer) psmAct <= wrData[PS_W-1:0];
      end
    end
  end

  always_comb begin
    evtVec = '0;
    evtVec[EVT_TIMEOUT] = timeoutEvt;
    evtVec[EVT_MATCH]   = matchEvt;
    clrVec = clearWr ? wrData[NUM_EVT-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawReg <= '0;
    else       rawReg <= (rawReg & ~clrVec) | evtVec;
  end

  assign rawIrq    = rawReg;
  assign maskedIrq = rawReg & maskReg;
  assign running   = enReg;

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutEvt && modeReg == MODE_ONESHOT && !ctrlWr) |=> !enReg);

  // R12
  clear_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && wrData[EVT_TIMEOUT] && !timeoutEvt) |=> !rawReg[EVT_TIMEOUT]);

  // R12
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutEvt |=> rawReg[EVT_TIMEOUT]);

  // R11
  deferred_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (matchWr && mDefer && !timeoutEvt && !startNow) |=> $stable(matchAct));

  // R5
  periodic_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutEvt && modeReg == MODE_PERIODIC && !ctrlWr) |=> enReg);
endmodule

// File: rtl/prescaled_timer.sv
`timescale 1ns/1ps
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8,
  localparam int DATA_W = CNT_W + PS_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [CNT_W-1:0]   count,
  output logic [PS_W-1:0]    prescale,
  output logic               running,
  output logic [NUM_EVT-1:0] rawIrq,
  output logic [NUM_EVT-1:0] maskedIrq
);
  dpStrobe_t st;
  logic [CNT_W-1:0] forceVal, loadVal, matchVal;
  logic [PS_W-1:0]  pscale, psMatchVal;
  logic timeoutEvt, matchEvt;

  tmr_ctrl #(.CNT_W(CNT_W), .PS_W(PS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .timeoutEvt(timeoutEvt), .matchEvt(matchEvt), .st(st),
    .forceVal(forceVal), .loadVal(loadVal), .pscale(pscale),
    .matchVal(matchVal), .psMatchVal(psMatchVal),
    .rawIrq(rawIrq), .maskedIrq(maskedIrq), .running(running)
  );

  tmr_datapath #(.CNT_W(CNT_W), .PS_W(PS_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .forceVal(forceVal), .loadVal(loadVal),
    .pscale(pscale), .matchVal(matchVal), .psMatchVal(psMatchVal),
    .timeoutEvt(timeoutEvt), .matchEvt(matchEvt), .cnt(count), .ps(prescale)
  );
endmodule

// File: tb/tb_prescaled_timer.sv
`timescale 1ns/1ps
module tb_prescaled_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [23:0] wrData = '0;
  logic [15:0] count;
  logic [7:0] prescale;
  logic running;
  logic [1:0] rawIrq, maskedIrq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prescaled_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .prescale(prescale), .running(running),
    .rawIrq(rawIrq), .maskedIrq(maskedIrq)
  );

  function automatic logic [23:0] ctl(input logic en, input logic stall, input logic up,
                                      input logic [1:0] mode, input logic ldDef,
                                      input logic mDef, input logic mIe);
    return {16'd0, mIe, mDef, ldDef, mode, up, stall, en};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Called at a negedge; the write lands on the next posedge, returns after it.
  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 count", count, 16'hFFFF);
    chk("R1 prescale", prescale, 0);
    chk("R1 running", running, 0);
    chk("R1 raw", rawIrq, 0);
    chk("R1 masked", maskedIrq, 0);
  endtask

  task automatic testDownPeriodic();
    doReset();
    wr(3'd1, 24'd3);
    wr(3'd3, 24'd1);
    wr(3'd0, ctl(1, 0, 0, 2, 0, 0, 0));
    chk("R2 start count", count, 3);
    chk("R2 prescaler loaded", prescale, 1);
    waitEdges(1);
    chk("R3 count held", count, 3);
    chk("R3 prescaler down", prescale, 0);
    waitEdges(1);
    chk("R3 count stepped", count, 2);
    waitEdges(5);
    chk("R4 no early timeout", rawIrq[0], 0);
    chk("R4 at zero", count, 0);
    waitEdges(1);
    chk("R4 timeout raw", rawIrq[0], 1);
    chk("R4 reload", count, 3);
    waitEdges(2);
    chk("R5 still running", running, 1);
    chk("R5 counting on", count, 2);
  endtask

  task automatic testOneShot();
    doReset();
    wr(3'd1, 24'd2);
    wr(3'd0, ctl(1, 0, 0, 1, 0, 0, 0));
    waitEdges(2);
    chk("R6 before timeout", running, 1);
    waitEdges(1);
    chk("R6 stopped", running, 0);
    chk("R6 timeout raw", rawIrq[0], 1);
    waitEdges(3);
    chk("R6 count held", count, 2);
  endtask

  task automatic testUp();
    doReset();
    wr(3'd1, 24'd4);
    wr(3'd5, 24'd0);
    wr(3'd0, ctl(1, 0, 1, 2, 0, 0, 0));
    chk("R7 start", count, 0);
    waitEdges(4);
    chk("R7 at limit", count, 4);
    chk("R7 no timeout yet", rawIrq[0], 0);
    waitEdges(1);
    chk("R7 wrapped", count, 0);
    chk("R7 timeout raw", rawIrq[0], 1);
  endtask

  task automatic testLoadMode();
    doReset();
    wr(3'd1, 24'd9);
    wr(3'd0, ctl(1, 0, 0, 2, 0, 0, 0));
    wr(3'd1, 24'd5);
    chk("R8 immediate load", count, 5);
    wr(3'd0, ctl(1, 0, 0, 2, 1, 0, 0));
    wr(3'd1, 24'd7);
    chk("R8 deferred untouched", count, 3);
    waitEdges(3);
    chk("R8 reaches zero", count, 0);
    waitEdges(1);
    chk("R8 deferred reload", count, 7);
  endtask

  task automatic testValueStall();
    doReset();
    wr(3'd3, 24'd5);
    wr(3'd0, ctl(1, 0, 0, 2, 0, 0, 0));
    wr(3'd0, ctl(1, 1, 0, 2, 0, 0, 0));
    wr(3'd5, 24'hAB0123);
    chk("R9 value low bits", count, 16'h0123);
    chk("R9 prescaler untouched", prescale, 4);
    waitEdges(3);
    chk("R13 count stalled", count, 16'h0123);
    chk("R13 prescaler stalled", prescale, 4);
    wr(3'd0, ctl(1, 0, 0, 2, 0, 0, 0));
    waitEdges(1);
    chk("R13 resumes", prescale, 3);
  endtask

  task automatic testMatch();
    doReset();
    wr(3'd1, 24'd3);
    wr(3'd2, 24'd1);
    wr(3'd4, 24'd0);
    wr(3'd6, 24'd3);
    wr(3'd0, ctl(1, 0, 0, 2, 0, 0, 1));
    waitEdges(2);
    chk("R10 not yet", rawIrq[1], 0);
    waitEdges(1);
    chk("R10 match raw", rawIrq[1], 1);
    chk("R12 match masked", maskedIrq[1], 1);
    doReset();
    wr(3'd1, 24'd3);
    wr(3'd2, 24'd1);
    wr(3'd0, ctl(1, 0, 0, 2, 0, 0, 0));
    waitEdges(10);
    chk("R10 disabled no match", rawIrq[1], 0);
  endtask

  task automatic testMatchDefer();
    doReset();
    wr(3'd1, 24'd3);
    wr(3'd2, 24'd7);
    wr(3'd0, ctl(0, 0, 0, 2, 0, 1, 0));
    wr(3'd2, 24'd2);
    wr(3'd0, ctl(1, 0, 0, 2, 0, 1, 1));
    waitEdges(2);
    chk("R11 applied at enable", rawIrq[1], 1);
    wr(3'd2, 24'd0);
    wr(3'd7, 24'd2);
    chk("R11 deferred while running", rawIrq[1], 0);
    waitEdges(3);
    chk("R11 new value not yet hit", rawIrq[1], 0);
    waitEdges(1);
    chk("R11 applied after timeout", rawIrq[1], 1);
  endtask

  task automatic testMaskClear();
    doReset();
    wr(3'd1, 24'd1);
    wr(3'd0, ctl(1, 0, 0, 1, 0, 0, 0));
    waitEdges(2);
    chk("R12 raw set", rawIrq[0], 1);
    chk("R12 masked off", maskedIrq[0], 0);
    wr(3'd6, 24'd1);
    chk("R12 masked on", maskedIrq[0], 1);
    wr(3'd7, 24'd0);
    chk("R12 zero clear ignored", rawIrq[0], 1);
    wr(3'd7, 24'd1);
    chk("R12 raw cleared", rawIrq[0], 0);
    chk("R12 masked cleared", maskedIrq[0], 0);
  endtask

  task automatic testReservedModes();
    doReset();
    wr(3'd1, 24'd5);
    wr(3'd0, ctl(1, 0, 0, 0, 0, 0, 0));
    waitEdges(4);
    chk("R14 mode 0 holds", count, 5);
    wr(3'd0, ctl(1, 0, 0, 3, 0, 0, 0));
    waitEdges(4);
    chk("R14 mode 3 holds", count, 5);
    chk("R14 no events", rawIrq, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testDownPeriodic();
    testOneShot();
    testUp();
    testLoadMode();
    testValueStall();
    testMatch();
    testMatchDefer();
    testMaskClear();
    testReservedModes();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule